// File: doc/BRIEF.md
# Flash Block-Erase Command Sequencer

This block models the command interface on the device side of a NOR flash, cut down to the block-erase path. It watches single-cycle bus writes (address, data byte, write strobe) and recognises the six-write erase command. That command is two unlock writes, a setup write, two more unlock writes and a confirm write. The address of the confirm write names the block to erase.

After the confirm write a retriggerable window opens. More confirm writes inside the window add further blocks to the same erase, and each of them restarts the window. When the window runs out, the modelled erase works through the chosen blocks in ascending index order. Each block is first forced to all-zero and then cleared to all-ones. Reads then return a status byte, with suspend, reset, completion and a forced-failure path.

The array contents are reduced to two flags per block, erased and zeroed. A block read in array mode returns FFh if the block is erased, 00h if it is zeroed, and A5h otherwise. The window length, the two phase durations and the failure limit are parameters counted in clock cycles.

Top module: `fls_erase_seq`

## Requirements
- R1: After reset every block has both flags clear. A read of any block returns A5h, with the data appearing one cycle after the read strobe.
- R2: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and then 30h@X select the block given by the top log2(NBLK) address bits of X. When the erase finishes, that block's erased flag is set and an array read of it returns FFh.
- R3: A write that does not match the next expected step of the six-write command returns the sequencer to read-array mode. A later confirm write then starts nothing, and reads return array data.
- R4: During the window, each further 30h write adds its block and restarts the window. Status bit 3 reads 0 for status reads sampled within TIMEOUT_CYC cycles of the last confirm write and reads 1 afterwards. Blocks are erased in ascending index order, each taking PRE_CYC+ERS_CYC cycles.
- R5: A write of any value other than 30h during the window cancels the command and returns to read-array mode, with no block flag changed.
- R6: The status byte carries bit7 = done, bit6 = toggle, bit5 = failed and bit3 = window expired; all other bits read 0. Bit7 reads 0 during the window and the erase and reads 1 once the erase has completed. Bit6 inverts on every status read during the window, the erase or the failed state, and holds its value once the erase is complete.
- R7: Each selected block first spends PRE_CYC cycles in a zeroing step, after which its zeroed flag is set and its erased flag is clear, so array reads return 00h. The two flags are never both set.
- R8: While force_fail is high, the clearing step never completes. After MAX_CYC clearing cycles the failed state is entered: bit5 reads 1 and bit7 reads 0. The failed state ignores every write except F0h.
- R9: During the erase, writes other than B0h and F0h are ignored and the erase carries on to completion.
- R10: A B0h write during the erase suspends it. Status then reads bit7 = 1 and bit3 = 1, bit6 holds, and no flag changes. A 30h write resumes the erase.
- R11: An F0h write during the erase returns to read-array mode. Blocks already finished keep their erased flag, and a partly treated block keeps its zeroed flag.
- R12: After completion, any write returns the sequencer to read-array mode, and reads then return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Bus address for reads and writes |
| wdata | input | 8 | Write data byte |
| we | input | 1 | Write strobe, one cycle per write |
| re | input | 1 | Read strobe, one cycle per read |
| force_fail | input | 1 | Test input that stops the clearing step from completing |
| rdata | output | 8 | Read data, registered, valid the cycle after re |
| blk_erased | output | NBLK | Per-block erased flag |
| blk_zeroed | output | NBLK | Per-block zeroed flag |

## Verification
Every read returns its byte one cycle after the strobe, and every write acts on the edge where it is presented. The bench therefore drives at one falling edge and samples at the next. Polling reads start on the cycle after the last confirm write, so the first read that shows done is due on the poll at count TIMEOUT_CYC + n·(PRE_CYC+ERS_CYC) + 2, where n is the number of blocks. The first read that shows failure is due at TIMEOUT_CYC + PRE_CYC + MAX_CYC + 1, and status bit 3 must flip exactly after poll TIMEOUT_CYC. The bench compares these counts arithmetically. It checks the zeroing step and suspension with fixed idle delays, counted edge by edge from the window expiry.

// File: rtl/fls_pkg.sv
package fls_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_U1,
        ST_U2,
        ST_U3,
        ST_U4,
        ST_U5,
        ST_WIN,
        ST_ERASE,
        ST_SUSP,
        ST_DONE,
        ST_FAIL
    } fls_state_e;

    typedef enum logic {
        PH_ZERO,
        PH_CLEAR
    } fls_phase_e;

    localparam logic [7:0] CMD_UNLK1   = 8'hAA;
    localparam logic [7:0] CMD_UNLK2   = 8'h55;
    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_CONFIRM = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] FILL_BYTE   = 8'hA5;

    function automatic logic shows_status(fls_state_e s);
        return (s == ST_WIN) || (s == ST_ERASE) || (s == ST_SUSP) ||
               (s == ST_DONE) || (s == ST_FAIL);
    endfunction

    function automatic logic toggles_on_read(fls_state_e s);
        return (s == ST_WIN) || (s == ST_ERASE) || (s == ST_FAIL);
    endfunction

endpackage

// File: rtl/fls_bus_decode.sv
module fls_bus_decode
    import fls_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              BLK_W    = 3,
    parameter logic [ADDR_W-1:0] UNLOCK_A = 16'h5555,
    parameter logic [ADDR_W-1:0] UNLOCK_B = 16'h2AAA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              we,
    output logic              hit_unlk1,
    output logic              hit_unlk2,
    output logic              hit_setup,
    output logic              hit_confirm,
    output logic              hit_suspend,
    output logic              hit_reset,
    output logic [BLK_W-1:0]  blk_idx
);

    logic at_a;
    logic at_b;

    assign at_a        = (addr == UNLOCK_A);
    assign at_b        = (addr == UNLOCK_B);
    assign hit_unlk1   = we && at_a && (wdata == CMD_UNLK1);
    assign hit_unlk2   = we && at_b && (wdata == CMD_UNLK2);
    assign hit_setup   = we && at_a && (wdata == CMD_SETUP);
    assign hit_confirm = we && (wdata == CMD_CONFIRM);
    assign hit_suspend = we && (wdata == CMD_SUSPEND);
    assign hit_reset   = we && (wdata == CMD_RESET);
    assign blk_idx     = addr[ADDR_W-1 -: BLK_W];

endmodule

// File: rtl/fls_cmd_fsm.sv
module fls_cmd_fsm
    import fls_pkg::*;
#(
    parameter int TMO_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       hit_unlk1,
    input  logic       hit_unlk2,
    input  logic       hit_setup,
    input  logic       hit_confirm,
    input  logic       hit_suspend,
    input  logic       hit_reset,
    input  logic       eng_empty,
    input  logic       eng_fail,
    output fls_state_e st,
    output logic       eng_start,
    output logic       eng_add,
    output logic       eng_clr,
    output logic       eng_run
);

    localparam int TMR_W = $clog2(TMO_CYC + 1);

    typedef struct packed {
        fls_state_e       st;
        logic [TMR_W-1:0] tmr;
    } fsm_regs_t;

    fsm_regs_t fsm_q, fsm_d;

    always_comb begin
        fsm_d     = fsm_q;
        eng_start = 1'b0;
        eng_add   = 1'b0;
        eng_clr   = 1'b0;
        eng_run   = 1'b0;
        case (fsm_q.st)
            ST_IDLE: if (hit_unlk1) fsm_d.st = ST_U1;
            ST_U1:   if (we) fsm_d.st = hit_unlk2 ? ST_U2 : ST_IDLE;
            ST_U2:   if (we) fsm_d.st = hit_setup ? ST_U3 : ST_IDLE;
            ST_U3:   if (we) fsm_d.st = hit_unlk1 ? ST_U4 : ST_IDLE;
            ST_U4:   if (we) fsm_d.st = hit_unlk2 ? ST_U5 : ST_IDLE;
            ST_U5: begin
                if (we) begin
                    if (hit_confirm) begin
                        fsm_d.st  = ST_WIN;
                        fsm_d.tmr = '0;
                        eng_start = 1'b1;
                    end else begin
                        fsm_d.st = ST_IDLE;
                    end
                end
            end
            ST_WIN: begin
                if (we) begin
                    if (hit_confirm) begin
                        fsm_d.tmr = '0;
                        eng_add   = 1'b1;
                    end else begin
                        fsm_d.st = ST_IDLE;
                        eng_clr  = 1'b1;
                    end
                end else if (fsm_q.tmr == TMR_W'(TMO_CYC - 1)) begin
                    fsm_d.st = ST_ERASE;
                end else begin
                    fsm_d.tmr = fsm_q.tmr + 1'b1;
                end
            end
            ST_ERASE: begin
                if (hit_suspend) begin
                    fsm_d.st = ST_SUSP;
                end else if (hit_reset) begin
                    fsm_d.st = ST_IDLE;
                    eng_clr  = 1'b1;
                end else begin
                    eng_run = 1'b1;
                    if (eng_fail) begin
                        fsm_d.st = ST_FAIL;
                    end else if (eng_empty) begin
                        fsm_d.st = ST_DONE;
                    end
                end
            end
            ST_SUSP: begin
                if (hit_confirm) begin
                    fsm_d.st = ST_ERASE;
                end else if (hit_reset) begin
                    fsm_d.st = ST_IDLE;
                    eng_clr  = 1'b1;
                end
            end
            ST_DONE: if (we) fsm_d.st = ST_IDLE;
            ST_FAIL: begin
                if (hit_reset) begin
                    fsm_d.st = ST_IDLE;
                    eng_clr  = 1'b1;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, tmr: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign st = fsm_q.st;

endmodule

// File: rtl/fls_erase_engine.sv
module fls_erase_engine
    import fls_pkg::*;
#(
    parameter int NBLK    = 8,
    parameter int PRE_CYC = 4,
    parameter int ERS_CYC = 8,
    parameter int MAX_CYC = 80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     add,
    input  logic                     clr,
    input  logic                     run,
    input  logic                     force_fail,
    input  logic [$clog2(NBLK)-1:0]  blk_idx,
    output logic                     empty,
    output logic                     fail_now,
    output logic [NBLK-1:0]          blk_erased,
    output logic [NBLK-1:0]          blk_zeroed
);

    localparam int BLK_W  = $clog2(NBLK);
    localparam int PH_MAX = (PRE_CYC > ERS_CYC) ? PRE_CYC : ERS_CYC;
    localparam int CNT_W  = $clog2(PH_MAX + 1);
    localparam int ECNT_W = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [NBLK-1:0]   sel;
        logic [NBLK-1:0]   erased;
        logic [NBLK-1:0]   zeroed;
        fls_phase_e        phase;
        logic [CNT_W-1:0]  pcnt;
        logic [ECNT_W-1:0] ecnt;
    } eng_regs_t;

    eng_regs_t eng_q, eng_d;

    logic [NBLK-1:0]  idx_mask;
    logic [BLK_W-1:0] cur;
    logic             blk_done;

    for (genvar g = 0; g < NBLK; g++) begin : g_mask
        assign idx_mask[g] = (blk_idx == BLK_W'(g));
    end

    always_comb begin
        cur = '0;
        for (int i = NBLK - 1; i >= 0; i--) begin
            if (eng_q.sel[i]) cur = BLK_W'(i);
        end
    end

    assign empty    = (eng_q.sel == '0);
    assign blk_done = !force_fail && (eng_q.phase == PH_CLEAR) &&
                      (eng_q.pcnt == CNT_W'(ERS_CYC - 1));
    assign fail_now = !empty && (eng_q.phase == PH_CLEAR) && !blk_done &&
                      (eng_q.ecnt == ECNT_W'(MAX_CYC - 1));

    always_comb begin
        eng_d = eng_q;
        if (clr) begin
            eng_d.sel   = '0;
            eng_d.phase = PH_ZERO;
            eng_d.pcnt  = '0;
            eng_d.ecnt  = '0;
        end else if (start) begin
            eng_d.sel   = idx_mask;
            eng_d.phase = PH_ZERO;
            eng_d.pcnt  = '0;
            eng_d.ecnt  = '0;
        end else if (add) begin
            eng_d.sel = eng_q.sel | idx_mask;
        end else if (run && !empty && !fail_now) begin
            if (eng_q.phase == PH_ZERO) begin
                if (eng_q.pcnt == CNT_W'(PRE_CYC - 1)) begin
                    eng_d.zeroed[cur] = 1'b1;
                    eng_d.erased[cur] = 1'b0;
                    eng_d.phase       = PH_CLEAR;
                    eng_d.pcnt        = '0;
                end else begin
                    eng_d.pcnt = eng_q.pcnt + 1'b1;
                end
            end else begin
                eng_d.ecnt = eng_q.ecnt + 1'b1;
                if (blk_done) begin
                    eng_d.erased[cur] = 1'b1;
                    eng_d.zeroed[cur] = 1'b0;
                    eng_d.sel[cur]    = 1'b0;
                    eng_d.phase       = PH_ZERO;
                    eng_d.pcnt        = '0;
                end else if (!force_fail) begin
                    eng_d.pcnt = eng_q.pcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{sel: '0, erased: '0, zeroed: '0, phase: PH_ZERO,
                       pcnt: '0, ecnt: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign blk_erased = eng_q.erased;
    assign blk_zeroed = eng_q.zeroed;

endmodule

// File: rtl/fls_read_port.sv
module fls_read_port
    import fls_pkg::*;
#(
    parameter int NBLK = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    re,
    input  fls_state_e              st,
    input  logic [$clog2(NBLK)-1:0] blk_idx,
    input  logic [NBLK-1:0]         blk_erased,
    input  logic [NBLK-1:0]         blk_zeroed,
    output logic [7:0]              rdata
);

    typedef struct packed {
        logic [7:0] data;
        logic       tgl;
    } rd_regs_t;

    rd_regs_t   rd_q, rd_d;
    logic [7:0] arr_byte [NBLK];
    logic [7:0] stat_byte;

    for (genvar g = 0; g < NBLK; g++) begin : g_arr
        assign arr_byte[g] = blk_erased[g] ? 8'hFF :
                             blk_zeroed[g] ? 8'h00 : FILL_BYTE;
    end

    assign stat_byte = {(st == ST_SUSP) || (st == ST_DONE),
                        rd_q.tgl,
                        (st == ST_FAIL),
                        1'b0,
                        (st != ST_WIN),
                        3'b000};

    always_comb begin
        rd_d = rd_q;
        if (re) begin
            rd_d.data = shows_status(st) ? stat_byte : arr_byte[blk_idx];
            if (toggles_on_read(st)) rd_d.tgl = ~rd_q.tgl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '{data: '0, tgl: 1'b0};
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.data;

endmodule

// File: rtl/fls_erase_seq.sv
module fls_erase_seq
    import fls_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                NBLK     = 8,
    parameter int                TMO_CYC  = 16,
    parameter int                PRE_CYC  = 4,
    parameter int                ERS_CYC  = 8,
    parameter int                MAX_CYC  = 80,
    parameter logic [ADDR_W-1:0] UNLOCK_A = 16'h5555,
    parameter logic [ADDR_W-1:0] UNLOCK_B = 16'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              we,
    input  logic              re,
    input  logic              force_fail,
    output logic [7:0]        rdata,
    output logic [NBLK-1:0]   blk_erased,
    output logic [NBLK-1:0]   blk_zeroed
);

    localparam int BLK_W = $clog2(NBLK);

    logic             hit_unlk1, hit_unlk2, hit_setup;
    logic             hit_confirm, hit_suspend, hit_reset;
    logic [BLK_W-1:0] blk_idx;
    logic             eng_start, eng_add, eng_clr, eng_run;
    logic             eng_empty, eng_fail;
    fls_state_e       st;

    fls_bus_decode #(
        .ADDR_W   (ADDR_W),
        .BLK_W    (BLK_W),
        .UNLOCK_A (UNLOCK_A),
        .UNLOCK_B (UNLOCK_B)
    ) u_dec (
        .addr        (addr),
        .wdata       (wdata),
        .we          (we),
        .hit_unlk1   (hit_unlk1),
        .hit_unlk2   (hit_unlk2),
        .hit_setup   (hit_setup),
        .hit_confirm (hit_confirm),
        .hit_suspend (hit_suspend),
        .hit_reset   (hit_reset),
        .blk_idx     (blk_idx)
    );

    fls_cmd_fsm #(
        .TMO_CYC (TMO_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (we),
        .hit_unlk1   (hit_unlk1),
        .hit_unlk2   (hit_unlk2),
        .hit_setup   (hit_setup),
        .hit_confirm (hit_confirm),
        .hit_suspend (hit_suspend),
        .hit_reset   (hit_reset),
        .eng_empty   (eng_empty),
        .eng_fail    (eng_fail),
        .st          (st),
        .eng_start   (eng_start),
        .eng_add     (eng_add),
        .eng_clr     (eng_clr),
        .eng_run     (eng_run)
    );

    fls_erase_engine #(
        .NBLK    (NBLK),
        .PRE_CYC (PRE_CYC),
        .ERS_CYC (ERS_CYC),
        .MAX_CYC (MAX_CYC)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (eng_start),
        .add        (eng_add),
        .clr        (eng_clr),
        .run        (eng_run),
        .force_fail (force_fail),
        .blk_idx    (blk_idx),
        .empty      (eng_empty),
        .fail_now   (eng_fail),
        .blk_erased (blk_erased),
        .blk_zeroed (blk_zeroed)
    );

    fls_read_port #(
        .NBLK (NBLK)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .re         (re),
        .st         (st),
        .blk_idx    (blk_idx),
        .blk_erased (blk_erased),
        .blk_zeroed (blk_zeroed),
        .rdata      (rdata)
    );

endmodule

// File: rtl/fls_erase_seq_chk.sv
module fls_erase_seq_chk
    import fls_pkg::*;
#(
    parameter int NBLK = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            we,
    input logic            re,
    input logic [7:0]      wdata,
    input logic [7:0]      rdata,
    input fls_state_e      st,
    input logic [NBLK-1:0] blk_erased,
    input logic [NBLK-1:0] blk_zeroed
);

    // R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_erased & blk_zeroed) == '0);

    // R6
    busy_dq7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && (st == ST_WIN || st == ST_ERASE)) |=> !rdata[7]);

    // R6
    done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && st == ST_DONE) |=> (rdata[7] && rdata[3] && !rdata[5]));

    // R8
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAIL && !(we && wdata == CMD_RESET)) |=> st == ST_FAIL);

    // R8
    fail_dq5_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && st == ST_FAIL) |=> (rdata[5] && !rdata[7]));

    // R5
    win_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WIN && we && wdata != CMD_CONFIRM) |=> st == ST_IDLE);

    // R11
    flag_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blk_erased) |-> $past(st) == ST_ERASE);

    // R10
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_SUSP |=> ($stable(blk_erased) && $stable(blk_zeroed)));

endmodule

bind fls_erase_seq fls_erase_seq_chk #(.NBLK(NBLK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (we),
    .re         (re),
    .wdata      (wdata),
    .rdata      (rdata),
    .st         (st),
    .blk_erased (blk_erased),
    .blk_zeroed (blk_zeroed)
);

// File: tb/fls_erase_seq_tb.sv
module fls_erase_seq_tb;

    localparam int T  = 16;
    localparam int PC = 4;
    localparam int EC = 8;
    localparam int MC = 80;
    localparam int BC = PC + EC;

    logic        clk;
    logic        rst_n;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        we;
    logic        re;
    logic        force_fail;
    logic [7:0]  rdata;
    logic [7:0]  blk_erased;
    logic [7:0]  blk_zeroed;

    int checks = 0;
    int errors = 0;

    fls_erase_seq #(
        .ADDR_W (16), .NBLK (8), .TMO_CYC (T), .PRE_CYC (PC),
        .ERS_CYC (EC), .MAX_CYC (MC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wdata (wdata),
        .we (we), .re (re), .force_fail (force_fail), .rdata (rdata),
        .blk_erased (blk_erased), .blk_zeroed (blk_zeroed)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ba(input int b);
        return {b[2:0], 13'h0ABC};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; we = 1'b0; re = 1'b0; force_fail = 1'b0;
        addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic seq6(input logic [15:0] a);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(a, 8'h30);
    endtask

    // polls status until done or failed; counts dq3 and dq6 deviations
    task automatic poll(output int n, output int dq3_bad, output int dq6_bad,
                        output logic [7:0] last);
        logic [7:0] v;
        logic       prev6;
        n = 0; dq3_bad = 0; dq6_bad = 0; prev6 = 1'b0; v = '0;
        while (n < 400) begin
            rd(16'h0000, v);
            n++;
            if (v[3] != (n > T)) dq3_bad++;
            if (n > 1 && v[6] == prev6) dq6_bad++;
            prev6 = v[6];
            if (v[7] || v[5]) break;
        end
        last = v;
    endtask

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, v2, last;
        logic [7:0] mask;
        int n, b3, b6;

        do_reset();
        // R1 reset state
        chk(blk_erased == 8'h00, "R1 erased flags", blk_erased, 8'h00);
        chk(blk_zeroed == 8'h00, "R1 zeroed flags", blk_zeroed, 8'h00);
        rd(ba(0), v);
        chk(v == 8'hA5, "R1 array read", v, 8'hA5);

        // R3 broken unlock and broken setup
        wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55);
        wr(16'h5555, 8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
        wr(ba(1), 8'h30);
        rd(ba(1), v);
        chk(v == 8'hA5, "R3 bad unlock address", v, 8'hA5);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h90);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(ba(1), 8'h30);
        rd(ba(1), v);
        chk(v == 8'hA5, "R3 bad setup byte", v, 8'hA5);
        idle(80);
        chk(blk_erased == 8'h00, "R3 nothing erased", blk_erased, 8'h00);

        // R5 abort in window
        seq6(ba(1));
        idle(3);
        wr(ba(1), 8'h00);
        rd(ba(1), v);
        chk(v == 8'hA5, "R5 abort read array", v, 8'hA5);
        idle(100);
        chk(blk_erased == 8'h00 && blk_zeroed == 8'h00, "R5 flags unchanged",
            {blk_erased, blk_zeroed}, 16'h0000);

        // R2 R6 R12 sweep over every block, single-block erases
        mask = 8'h00;
        for (int b = 0; b < 8; b++) begin
            seq6(ba(b));
            poll(n, b3, b6, last);
            mask[b] = 1'b1;
            chk(n == T + BC + 2, "R2 done poll index", n, T + BC + 2);
            chk(last[7] && !last[5] && last[3], "R6 done status", last, 8'h88);
            chk(b3 == 0, "R4 dq3 window timing", b3, 0);
            chk(b6 == 0, "R6 dq6 toggling", b6, 0);
            rd(16'h0000, v2);
            chk(v2[6] == last[6] && v2[7], "R6 dq6 stable when done", v2, last);
            wr(16'h0000, 8'h00);
            rd(ba(b), v);
            chk(v == 8'hFF, "R12 array after done", v, 8'hFF);
            chk(blk_erased == mask, "R2 erased mask", blk_erased, mask);
        end

        // R4 multi-block window with retrigger
        do_reset();
        seq6(ba(2)); idle(5);
        wr(ba(5), 8'h30); idle(5);
        wr(ba(6), 8'h30);
        poll(n, b3, b6, last);
        chk(n == T + 3 * BC + 2, "R4 three block duration", n, T + 3 * BC + 2);
        chk(b3 == 0, "R4 dq3 after retrigger", b3, 0);
        chk(b6 == 0, "R6 dq6 multi", b6, 0);
        chk(blk_erased == 8'h64, "R4 gathered blocks", blk_erased, 8'h64);
        wr(16'h0000, 8'h00);

        // R7 zeroing step, then R11 reset mid-erase
        do_reset();
        seq6(ba(3));
        idle(T + PC + 1);
        chk(blk_zeroed == 8'h08 && blk_erased == 8'h00, "R7 zeroed after pre-step",
            {blk_zeroed, blk_erased}, 16'h0800);
        wr(16'h5555, 8'hF0);
        rd(ba(3), v);
        chk(v == 8'h00, "R11 read array after reset", v, 8'h00);
        idle(50);
        chk(blk_erased == 8'h00, "R11 no completion after reset", blk_erased, 8'h00);

        // R9 ignored writes during erase
        do_reset();
        seq6(ba(4));
        idle(T + 2);
        wr(ba(4), 8'h80); wr(16'h5555, 8'hAA); wr(ba(4), 8'h30);
        rd(16'h0000, v);
        chk(!v[7] && v[3], "R9 still erasing", v, 8'h08);
        poll(n, b3, b6, last);
        chk(last[7] && blk_erased == 8'h10, "R9 erase completes",
            {last, blk_erased}, 16'h8810);
        wr(16'h0000, 8'h00);

        // R10 suspend and resume
        do_reset();
        seq6(ba(0));
        wr(ba(1), 8'h30);
        idle(T + 17);
        wr(16'h0000, 8'hB0);
        rd(16'h0000, v);
        chk(v[7] && v[3] && !v[5], "R10 suspended status", v, 8'h88);
        rd(16'h0000, v2);
        chk(v2[6] == v[6], "R10 dq6 held", v2, v);
        chk(blk_erased == 8'h01 && blk_zeroed == 8'h02, "R10 flags at suspend",
            {blk_erased, blk_zeroed}, 16'h0102);
        idle(60);
        chk(blk_erased == 8'h01 && blk_zeroed == 8'h02, "R10 no progress",
            {blk_erased, blk_zeroed}, 16'h0102);
        wr(16'h0000, 8'h30);
        poll(n, b3, b6, last);
        chk(last[7] && blk_erased == 8'h03 && blk_zeroed == 8'h00,
            "R10 resumed to completion", {blk_erased, blk_zeroed}, 16'h0300);
        wr(16'h0000, 8'h00);

        // R8 forced failure
        do_reset();
        force_fail = 1'b1;
        seq6(ba(7));
        poll(n, b3, b6, last);
        chk(n == T + PC + MC + 1, "R8 failure poll index", n, T + PC + MC + 1);
        chk(last[5] && !last[7], "R8 failure status", last, 8'h28);
        wr(16'h5555, 8'h80);
        rd(16'h0000, v);
        chk(v[5], "R8 failure held across write", v, 8'h28);
        wr(16'h0000, 8'hF0);
        force_fail = 1'b0;
        rd(ba(7), v);
        chk(v == 8'h00, "R8 reset leaves zeroed block", v, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule